// File: doc/BRIEF.md
# DRAM Distributed Refresh Scheduler

This block sits inside a memory controller and makes sure every DRAM row is refreshed within its retention window. A free-running interval timer raises refresh requests. A row counter names the row each refresh targets, and an arbiter fits refresh cycles in between host accesses. The period between requests is the retention time divided by the row count in distributed policy. In burst policy it is the whole retention time, and each request triggers a refresh of every row back to back. An over-temperature input halves the period under either policy.

Two refresh styles are offered. In the address-driven style the row counter is placed on the address lines while the row strobe is held for the whole refresh. In the internal-count style the column strobe leads the row strobe by one cycle and the address lines are left undriven (zero). Both styles advance the row counter. Host accesses use a request/ready handshake. An access that has already started always runs to its end. Once a refresh is owed, ready drops and stays low until the refresh work is done, so a new request cannot overtake a pending refresh.

The arbiter has three states: `ARB_IDLE`, `ARB_ACCESS` and `ARB_REFRESH`. Its transitions are:
- grant (IDLE to REFRESH when refreshes are owed)
- accept (IDLE to ACCESS on a request with none owed)
- access end (ACCESS to IDLE after the last access cycle)
- chain (REFRESH to REFRESH on the last cycle when more are owed)
- release (REFRESH to IDLE on the last cycle when none are owed)

Top module: `rfsh_sched`

## Requirements
- R1: Distributed policy, cool, host idle: successive refresh starts are RET_CYC/NUM_ROWS clock cycles apart (40 with defaults).
- R2: Burst policy: every RET_CYC cycles, NUM_ROWS refreshes run back to back. ref_busy stays high for NUM_ROWS*RFC_CYC cycles without a gap, and successive bursts start RET_CYC cycles apart.
- R3: The refresh row starts at 0 after reset. It rises by one (modulo NUM_ROWS) after every completed refresh in both styles.
- R4: Each refresh occupies exactly RFC_CYC (4) cycles of ref_busy. Outside refreshes, both strobes, mem_addr_oe and mem_addr are 0.
- R5: While ref_busy is 1, host_rdy is 0 and acc_busy is 0.
- R6: When temp_hot is 1, the request period is half its cool value under both policies (20 distributed, 320 burst with defaults).
- R7: Address-driven style (cfg_int_cnt=0): in every refresh cycle mem_row_stb=1, mem_col_stb=0, mem_addr_oe=1 and mem_addr equals the refresh row.
- R8: Internal-count style (cfg_int_cnt=1): in the first refresh cycle mem_col_stb=1 and mem_row_stb=0. In the remaining cycles both are 1. mem_addr_oe=0 and mem_addr=0 throughout.
- R9: An access is accepted when host_req and host_rdy are both 1 at a rising edge. acc_busy is then 1 for exactly ACC_CYC (2) cycles from the next cycle, and a refresh falling due during it does not shorten it.
- R10: An owed refresh is granted before any new request. With host_req held at 1, refreshes still occur at the timer rate, because the timer keeps counting while a refresh waits.
- R11: During reset: host_rdy=1, acc_busy=0, ref_busy=0, both strobes 0, mem_addr_oe=0, mem_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst | input | 1 | 1 selects burst policy, 0 distributed |
| cfg_int_cnt | input | 1 | 1 selects internal-count style, 0 address-driven |
| temp_hot | input | 1 | Over-temperature, halves the request period |
| host_req | input | 1 | Host access request |
| host_rdy | output | 1 | Host may start an access this cycle |
| acc_busy | output | 1 | Host access occupying the memory |
| ref_busy | output | 1 | Refresh cycle in progress |
| mem_row_stb | output | 1 | Row strobe toward the memory |
| mem_col_stb | output | 1 | Column strobe toward the memory |
| mem_addr_oe | output | 1 | Row address is being driven |
| mem_addr | output | $clog2(NUM_ROWS) | Refresh row address |

## Verification
The hardest case to reach is a refresh falling due while an access is mid-flight and another request is already waiting. The access must finish, the refresh must win the next slot, and the waiting request must be held off. The bench holds host_req high for many timer periods so that the request ticks land at every phase of the access pattern. It counts refreshes that start right after an access ends, and mixes in random request traffic plus random changes of temperature and style.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_ACCESS  = 2'd1,
        ARB_REFRESH = 2'd2
    } arb_state_t;

    typedef enum logic {
        STY_ADDR  = 1'b0,
        STY_COUNT = 1'b1
    } rfsh_style_t;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int RET_CYC  = 640,
    parameter int NUM_ROWS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst,
    input  logic hot,
    output logic tick
);
    localparam int DIST_CYC = RET_CYC / NUM_ROWS;
    localparam int CNT_W    = $clog2(RET_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;

    // period selection: policy first, then temperature halving
    always_comb begin
        period = burst ? CNT_W'(RET_CYC) : CNT_W'(DIST_CYC);
        if (hot) begin
            period = period >> 1;
        end
    end

    assign tick = (cnt_q >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(RET_CYC)); // R1
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
endmodule

// File: rtl/rfsh_rowctr.sv
module rfsh_rowctr #(
    parameter int NUM_ROWS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    output logic [$clog2(NUM_ROWS)-1:0] row
);
    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] row_q;

    generate
        if (NUM_ROWS == (1 << ROW_W)) begin : g_pow2
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    row_q <= '0;
                end else if (adv) begin
                    row_q <= row_q + 1'b1;
                end
            end
        end else begin : g_wrap
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    row_q <= '0;
                end else if (adv) begin
                    row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
                end
            end
        end
    endgenerate

    assign row = row_q;

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_q)); // R3
    AST_ROW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !$stable(row_q)); // R3
endmodule

// File: rtl/rfsh_arb.sv
module rfsh_arb
    import rfsh_pkg::*;
#(
    parameter int NUM_ROWS = 16,
    parameter int RFC_CYC  = 4,
    parameter int ACC_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic burst,
    input  logic int_cnt,
    input  logic host_req,
    output logic host_rdy,
    output logic acc_busy,
    output logic ref_busy,
    output logic row_stb,
    output logic col_stb,
    output logic addr_oe,
    output logic adv
);
    localparam int PH_MAX = (RFC_CYC > ACC_CYC) ? RFC_CYC : ACC_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int PEND_W = $clog2(NUM_ROWS + 1);
    localparam logic [PH_W-1:0]   RFC_LAST  = PH_W'(RFC_CYC - 1);
    localparam logic [PH_W-1:0]   ACC_LAST  = PH_W'(ACC_CYC - 1);
    localparam logic [PEND_W-1:0] PEND_FULL = PEND_W'(NUM_ROWS);

    arb_state_t        state_q, state_d;
    logic [PH_W-1:0]   phase_q, phase_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    rfsh_style_t       style_q;
    logic              ref_last, acc_last, start_ref;

    assign ref_last = (state_q == ARB_REFRESH) && (phase_q == RFC_LAST);
    assign acc_last = (state_q == ARB_ACCESS) && (phase_q == ACC_LAST);

    // owed-refresh count: burst reloads a full sweep, distributed adds one
    always_comb begin
        pend_d = pend_q;
        if (ref_last) begin
            pend_d = pend_q - 1'b1;
        end
        if (tick) begin
            if (burst) begin
                pend_d = PEND_FULL;
            end else if (pend_d != PEND_FULL) begin
                pend_d = pend_d + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        phase_d   = phase_q;
        start_ref = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (pend_q != '0) begin
                    state_d   = ARB_REFRESH;
                    phase_d   = '0;
                    start_ref = 1'b1;
                end else if (host_req) begin
                    state_d = ARB_ACCESS;
                    phase_d = '0;
                end
            end
            ARB_ACCESS: begin
                if (acc_last) begin
                    state_d = ARB_IDLE;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            ARB_REFRESH: begin
                if (ref_last) begin
                    phase_d = '0;
                    if (pend_d != '0) begin
                        start_ref = 1'b1;
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            phase_q <= '0;
            pend_q  <= '0;
            style_q <= STY_ADDR;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            pend_q  <= pend_d;
            if (start_ref) begin
                style_q <= rfsh_style_t'(int_cnt);
            end
        end
    end

    // outputs
    always_comb begin
        host_rdy = 1'b0;
        acc_busy = 1'b0;
        ref_busy = 1'b0;
        row_stb  = 1'b0;
        col_stb  = 1'b0;
        addr_oe  = 1'b0;
        adv      = 1'b0;
        unique case (state_q)
            ARB_IDLE:   host_rdy = (pend_q == '0);
            ARB_ACCESS: acc_busy = 1'b1;
            ARB_REFRESH: begin
                ref_busy = 1'b1;
                adv      = ref_last;
                if (style_q == STY_COUNT) begin
                    col_stb = 1'b1;
                    row_stb = (phase_q != '0);
                end else begin
                    row_stb = 1'b1;
                    addr_oe = 1'b1;
                end
            end
            default: ;
        endcase
    end

    AST_RDY_OFF_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> !host_rdy); // R5
    AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_FULL); // R2
    AST_REF_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_REFRESH && phase_q != '0) |->
        ($past(state_q) == ARB_REFRESH && $past(phase_q) == phase_q - 1'b1)); // R4
    AST_ACC_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_ACCESS && phase_q != ACC_LAST) |=> state_q == ARB_ACCESS); // R9
    AST_GRANT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && pend_q != '0) |=> state_q == ARB_REFRESH); // R10
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
    parameter int NUM_ROWS = 16,
    parameter int RET_CYC  = 640,
    parameter int RFC_CYC  = 4,
    parameter int ACC_CYC  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_burst,
    input  logic                        cfg_int_cnt,
    input  logic                        temp_hot,
    input  logic                        host_req,
    output logic                        host_rdy,
    output logic                        acc_busy,
    output logic                        ref_busy,
    output logic                        mem_row_stb,
    output logic                        mem_col_stb,
    output logic                        mem_addr_oe,
    output logic [$clog2(NUM_ROWS)-1:0] mem_addr
);
    localparam int ROW_W = $clog2(NUM_ROWS);

    logic             tick;
    logic             adv;
    logic [ROW_W-1:0] row;

    rfsh_timer #(.RET_CYC(RET_CYC), .NUM_ROWS(NUM_ROWS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .burst (cfg_burst),
        .hot   (temp_hot),
        .tick  (tick)
    );

    rfsh_rowctr #(.NUM_ROWS(NUM_ROWS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .row   (row)
    );

    rfsh_arb #(.NUM_ROWS(NUM_ROWS), .RFC_CYC(RFC_CYC), .ACC_CYC(ACC_CYC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .burst    (cfg_burst),
        .int_cnt  (cfg_int_cnt),
        .host_req (host_req),
        .host_rdy (host_rdy),
        .acc_busy (acc_busy),
        .ref_busy (ref_busy),
        .row_stb  (mem_row_stb),
        .col_stb  (mem_col_stb),
        .addr_oe  (mem_addr_oe),
        .adv      (adv)
    );

    assign mem_addr = mem_addr_oe ? row : '0;

    AST_ADDR_WITH_ROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_oe |-> (mem_row_stb && !mem_col_stb)); // R7
    AST_COUNT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_col_stb |-> (!mem_addr_oe && mem_addr == '0)); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_busy && acc_busy)); // R5
endmodule

// File: tb/tb_rfsh_sched.sv
module tb_rfsh_sched;
    localparam int NR  = 16;
    localparam int RET = 640;
    localparam int RFC = 4;
    localparam int ACC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_burst = 1'b0, cfg_int_cnt = 1'b0, temp_hot = 1'b0, host_req = 1'b0;
    logic host_rdy, acc_busy, ref_busy, mem_row_stb, mem_col_stb, mem_addr_oe;
    logic [3:0] mem_addr;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    rfsh_sched #(.NUM_ROWS(NR), .RET_CYC(RET), .RFC_CYC(RFC), .ACC_CYC(ACC)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_int_cnt(cfg_int_cnt),
        .temp_hot(temp_hot), .host_req(host_req), .host_rdy(host_rdy),
        .acc_busy(acc_busy), .ref_busy(ref_busy), .mem_row_stb(mem_row_stb),
        .mem_col_stb(mem_col_stb), .mem_addr_oe(mem_addr_oe), .mem_addr(mem_addr));

    function automatic int exp_period(bit burst, bit hot);
        int p = burst ? RET : RET / NR;
        return hot ? p / 2 : p;
    endfunction

    function automatic int exp_run(bit burst);
        return burst ? NR * RFC : RFC;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor state
    bit prev_busy = 0, acc_pend = 0, sty_b = 0, chk_space = 0, chk_run = 0;
    int ph = 0, exp_row = 0, nref = 0, nacc = 0, run_len = 0, acc_len = 0;
    int last_start = 0, last_acc_end = -100, settle = 1, after_acc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_pend) chk(acc_busy == 1'b1, "R9", "access begins after accept", int'(acc_busy), 1);
            acc_pend = host_req && host_rdy;
            if (acc_pend) nacc++;
            if (acc_busy) acc_len++;
            else if (acc_len != 0) begin
                chk(acc_len == ACC, "R9", "access length", acc_len, ACC);
                acc_len = 0;
                last_acc_end = cyc;
            end
            if (ref_busy) begin
                if (!prev_busy) begin
                    if (settle == 0) begin
                        if (chk_space)
                            chk(cyc - last_start == exp_period(cfg_burst, temp_hot),
                                temp_hot ? "R6" : (cfg_burst ? "R2" : "R1"), "start spacing",
                                cyc - last_start, exp_period(cfg_burst, temp_hot));
                    end else settle--;
                    last_start = cyc;
                    run_len = 0;
                    if (cyc - last_acc_end <= 2) after_acc++;
                end
                if (ph == 0) sty_b = cfg_int_cnt;
                chk(!host_rdy && !acc_busy, "R5", "host blocked during refresh",
                    int'(host_rdy) + int'(acc_busy), 0);
                if (sty_b)
                    chk(mem_col_stb && (mem_row_stb == (ph != 0)) && !mem_addr_oe && mem_addr == 0,
                        "R8", "internal-count strobes", {mem_row_stb, mem_col_stb, mem_addr_oe},
                        (ph != 0) ? 3'b110 : 3'b010);
                else
                    chk(mem_row_stb && !mem_col_stb && mem_addr_oe && mem_addr == exp_row,
                        "R3,R7", "address-driven row", int'(mem_addr), exp_row);
                run_len++;
                if (ph == RFC - 1) begin
                    ph = 0;
                    exp_row = (exp_row + 1) % NR;
                    nref++;
                end else ph++;
            end else begin
                if (prev_busy) begin
                    chk(ph == 0, "R4", "refresh ends on a whole cycle", ph, 0);
                    if (chk_run && settle == 0)
                        chk(run_len == exp_run(cfg_burst), cfg_burst ? "R2" : "R4", "busy run length",
                            run_len, exp_run(cfg_burst));
                end
                chk(!mem_row_stb && !mem_col_stb && !mem_addr_oe && mem_addr == 0, "R4",
                    "idle strobes quiet", {mem_row_stb, mem_col_stb, mem_addr_oe}, 0);
            end
            prev_busy = ref_busy;
        end
    end

    task automatic wait_refs(input int n);
        int target = nref + n;
        while (nref < target) @(negedge clk);
    endtask

    task automatic switch_cfg(input bit b, input bit h, input bit s);
        do @(negedge clk); while (!ref_busy);
        do @(negedge clk); while (ref_busy);
        @(posedge clk); #1;
        cfg_burst = b; temp_hot = h; cfg_int_cnt = s;
        settle = 2;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not end, actual cycles=%0d expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n0, a0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(host_rdy == 1'b1, "R11", "ready in reset", int'(host_rdy), 1);
        chk(!ref_busy && !acc_busy, "R11", "busy flags in reset", int'(ref_busy) + int'(acc_busy), 0);
        chk(!mem_row_stb && !mem_col_stb && !mem_addr_oe && mem_addr == 0, "R11", "memory pins in reset",
            {mem_row_stb, mem_col_stb, mem_addr_oe}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // distributed, cool, address-driven
        chk_space = 1; chk_run = 1; settle = 1;
        wait_refs(20);
        // hot
        switch_cfg(0, 1, 0);
        wait_refs(12);
        // internal-count style
        switch_cfg(0, 0, 1);
        wait_refs(8);
        // back to address-driven: row sequence must continue (R3)
        switch_cfg(0, 0, 0);
        wait_refs(4);

        // random traffic with random temperature and style changes
        chk_space = 0; chk_run = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            host_req = ($urandom % 2) == 1;
            if ((i % 300) == 150) temp_hot = ~temp_hot;
            if ((i % 500) == 250 && !ref_busy) cfg_int_cnt = ~cfg_int_cnt;
        end
        host_req = 1'b0;
        switch_cfg(0, 0, 0);
        chk_space = 1; chk_run = 1;
        wait_refs(3);

        // request held high: refreshes keep the timer rate (R10), accesses still served
        chk_space = 0;
        @(posedge clk); #1 host_req = 1'b1;
        n0 = nref; a0 = nacc; after_acc = 0;
        repeat (400) @(posedge clk);
        #1 host_req = 1'b0;
        chk((nref - n0) >= 9 && (nref - n0) <= 11, "R10", "refreshes under held request", nref - n0, 10);
        chk((nacc - a0) >= 100, "R9", "accesses under held request", nacc - a0, 100);
        chk(after_acc >= 1, "R9", "refresh waited for in-flight access", after_acc, 1);

        // burst policy, cool then hot
        switch_cfg(1, 0, 0);
        chk_space = 1; chk_run = 1;
        wait_refs(3 * NR);
        switch_cfg(1, 1, 0);
        wait_refs(3 * NR);

        repeat (5) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule